// File: doc/BRIEF.md
# Upstream Stream Ring Writer

This block takes a word stream from user logic and lays it into a ring of fixed-size buffers in host memory, one buffer after another in round-robin order. Writes go out on a simple write port that the surrounding DMA engine consumes. When a buffer fills, the block hands it to the host by queueing a 32-bit release message and raising an interrupt when one is due. The host never reads device registers. Everything it learns arrives as messages.

The host controls the block through three write-only commands. The first returns a buffer so that it can be reused. The second asks for an early hand-over of a partly filled buffer. The third acknowledges the interrupt. When a word arrives while the channel holds no data, the block queues a separate notice so that a waiting host poll does not miss data that is still in an unsubmitted buffer. Backpressure on the input stream keeps data from being lost when every buffer is owned by the host or when the message queue is short of space.

Top module: `stream_ring_writer`

## Requirements
- R1: After reset, `s_ready` is 1, `msg_valid` is 0 and `irq` is 0. The first buffer used is index 0 and the interrupt is armed.
- R2: A word is accepted when `s_valid && s_ready`. In that same cycle the write port shows `dma_wr_en`=1, `dma_wr_buf` = the current buffer index, `dma_wr_off` = the number of words already in that buffer, and `dma_wr_data` = `s_data`. When no word is accepted, `dma_wr_en` is 0.
- R3: Accepting the last word of a buffer submits that buffer with a release message. The message fields are: bits [31:28] opcode 4'h1, bits [27:20] the CHAN parameter, bits [19:14] the buffer index, and bits [13:0] the byte count minus one. The byte count is words × FMT_BITS/8. FMT_BITS is 8, 16 or 32, and NBUF and BUF_WORDS are powers of two.
- R4: Buffers are filled and submitted in index order 0,1,…,NBUF-1, and the order then wraps back to 0.
- R5: A submitted buffer belongs to the host. While the current buffer is host-owned, `s_ready` is 0 and nothing is written. A host write with `host_wr_sel`=0 and `host_wr_arg`=index returns that buffer, and `s_ready` can rise in the next cycle. Returning a buffer the host does not own has no effect.
- R6: A flush command (`host_wr_sel`=1) takes effect in the next cycle. If the current buffer then holds data, it is submitted partly filled, with its true byte count, in the first cycle that accepts no word and has queue room.
- R7: A flush that arrives while the current buffer is empty is remembered. The next accepted word closes the buffer it lands in, together with that word. Any word accepted while a flush is pending closes its buffer, counting that word.
- R8: When NONEMPTY_EN is set, accepting a word while the channel holds no data queues a notice `{4'h2, CHAN, 20'h0}`. "Holds no data" means the current buffer is empty and no buffer is host-owned. If a release is queued in the same cycle, the notice comes first.
- R9: `irq` is a one-cycle pulse. It rises in the cycle after a message is pushed into an empty queue while the interrupt is armed, and it disarms the interrupt. `host_wr_sel`=2 rearms it. If a firing and an acknowledge fall in the same cycle, the interrupt is left disarmed.
- R10: Messages leave in FIFO order. The head is shown on `msg_data` while `msg_valid` is 1, and it is removed by `msg_valid && msg_ready`. `s_ready` is 0 while fewer than two of the MSG_DEPTH queue slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | FMT_BITS | Input stream word |
| s_valid | input | 1 | Input word present |
| s_ready | output | 1 | Block can take a word |
| dma_wr_en | output | 1 | Write port strobe |
| dma_wr_buf | output | log2(NBUF) | Target buffer index |
| dma_wr_off | output | log2(BUF_WORDS) | Word offset in the buffer |
| dma_wr_data | output | FMT_BITS | Word to write |
| host_wr_en | input | 1 | Host command write strobe |
| host_wr_sel | input | 2 | 0 return buffer, 1 flush, 2 interrupt acknowledge, 3 none |
| host_wr_arg | input | log2(NBUF) | Buffer index for a return |
| msg_valid | output | 1 | Message queue not empty |
| msg_data | output | 32 | Head message word |
| msg_ready | input | 1 | Consumer takes the head message |
| irq | output | 1 | Interrupt pulse |

## Verification
The case that needs care is a single accepted word that both opens an empty channel and closes its buffer because a flush is pending. That one word queues the nonempty notice and a release in the same cycle, and the notice must be first. A directed sequence provokes this case. It returns every buffer, drains the queue, issues a flush and then sends one word; the two queued words are then checked against literal values in order. The random phase also hits the case by chance, along with host returns that land in the same cycle as a submit. Each cycle, a bench model compares the full queue contents, the ready signal and the interrupt against the design's outputs.

// File: rtl/stream_ring_writer.sv
`timescale 1ns/1ps
module stream_ring_writer #(
  parameter int NBUF        = 4,
  parameter int BUF_WORDS   = 8,
  parameter int FMT_BITS    = 32,
  parameter int CHAN        = 3,
  parameter int NONEMPTY_EN = 1,
  parameter int MSG_DEPTH   = 4,
  localparam int BI_W  = $clog2(NBUF),
  localparam int OFF_W = $clog2(BUF_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FMT_BITS-1:0] s_data,
  input  logic                s_valid,
  output logic                s_ready,
  output logic                dma_wr_en,
  output logic [BI_W-1:0]     dma_wr_buf,
  output logic [OFF_W-1:0]    dma_wr_off,
  output logic [FMT_BITS-1:0] dma_wr_data,
  input  logic                host_wr_en,
  input  logic [1:0]          host_wr_sel,
  input  logic [BI_W-1:0]     host_wr_arg,
  output logic                msg_valid,
  output logic [31:0]         msg_data,
  input  logic                msg_ready,
  output logic                irq
);
  localparam int BYTES = FMT_BITS / 8;
  localparam int AW    = $clog2(MSG_DEPTH);
  localparam int CW    = $clog2(MSG_DEPTH + 1);
  localparam logic [3:0] OP_REL = 4'h1;
  localparam logic [3:0] OP_NE  = 4'h2;

  logic [BI_W-1:0]  cur;
  logic [OFF_W-1:0] fill;
  logic [NBUF-1:0]  owned;
  logic             flush_pend, armed;
  logic [31:0]      mq [MSG_DEPTH];
  logic [AW-1:0]    rp, wp;
  logic [CW-1:0]    cnt;

  logic room, acc, chan_empty, post_ne, sub, pop, fire;
  logic host_ret, host_flush, host_ack;
  logic [OFF_W:0] rel_words;
  logic [13:0]    rel_cnt;
  logic [31:0]    rel_msg, ne_msg;
  logic [1:0]     n_push;

  assign room       = cnt <= CW'(MSG_DEPTH - 2);
  assign s_ready    = !owned[cur] && room;
  assign acc        = s_valid && s_ready;
  assign chan_empty = (fill == '0) && (owned == '0);
  assign post_ne    = acc && chan_empty && (NONEMPTY_EN != 0);
  assign sub        = acc ? ((fill == OFF_W'(BUF_WORDS - 1)) || flush_pend)
                          : (flush_pend && (fill != '0) && room);
  assign rel_words  = {1'b0, fill} + {{OFF_W{1'b0}}, acc};
  assign rel_cnt    = 14'(rel_words) * 14'(BYTES) - 14'd1;
  assign rel_msg    = {OP_REL, 8'(CHAN), 6'(cur), rel_cnt};
  assign ne_msg     = {OP_NE, 8'(CHAN), 20'd0};
  assign n_push     = {1'b0, post_ne} + {1'b0, sub};
  assign pop        = msg_ready && (cnt != '0);
  assign fire       = armed && (cnt == '0) && (n_push != 2'd0);

  assign host_ret   = host_wr_en && (host_wr_sel == 2'd0);
  assign host_flush = host_wr_en && (host_wr_sel == 2'd1);
  assign host_ack   = host_wr_en && (host_wr_sel == 2'd2);

  assign dma_wr_en   = acc;
  assign dma_wr_buf  = cur;
  assign dma_wr_off  = fill;
  assign dma_wr_data = s_data;
  assign msg_valid   = cnt != '0;
  assign msg_data    = mq[rp];

  always_ff @(posedge clk) begin
    if (n_push != 2'd0) mq[wp] <= post_ne ? ne_msg : rel_msg;
    if (n_push == 2'd2) mq[wp + AW'(1)] <= rel_msg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0; fill <= '0; owned <= '0; flush_pend <= 1'b0;
      armed <= 1'b1; irq <= 1'b0; rp <= '0; wp <= '0; cnt <= '0;
    end else begin
      if (pop) rp <= rp + AW'(1);
      wp  <= wp + AW'(n_push);
      cnt <= cnt + CW'(n_push) - CW'(pop);
      irq <= fire;
      if (host_ack) armed <= 1'b1;
      if (fire) armed <= 1'b0;
      if (sub) fill <= '0;
      else if (acc) fill <= fill + OFF_W'(1);
      if (sub) cur <= cur + BI_W'(1);
      if (host_ret) owned[host_wr_arg] <= 1'b0;
      if (sub) owned[cur] <= 1'b1;
      if (host_flush) flush_pend <= 1'b1;
      else if (sub) flush_pend <= 1'b0;
    end
  end

  assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr_en |-> !owned[dma_wr_buf]);
  assert_stall_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |-> !dma_wr_en);
  assert_submit_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sub |=> owned[$past(cur)]);
  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_queue_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MSG_DEPTH));
endmodule

// File: tb/stream_ring_writer_test.sv
`timescale 1ns/1ps
module stream_ring_writer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] s_data = '0;
  logic s_valid = 1'b0, s_ready;
  logic dma_wr_en; logic [1:0] dma_wr_buf; logic [2:0] dma_wr_off; logic [31:0] dma_wr_data;
  logic host_wr_en = 1'b0; logic [1:0] host_wr_sel = 2'd3; logic [1:0] host_wr_arg = '0;
  logic msg_valid; logic [31:0] msg_data; logic msg_ready = 1'b0; logic irq;

  int checks = 0, errors = 0;
  int m_cur = 0, m_fill = 0;
  logic [3:0] m_owned = '0;
  logic m_pend = 1'b0, m_armed = 1'b1, m_irq = 1'b0;
  logic [31:0] q[$];

  always #5 clk = ~clk;

  stream_ring_writer #(.NBUF(4), .BUF_WORDS(8), .FMT_BITS(32), .CHAN(3),
    .NONEMPTY_EN(1), .MSG_DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .dma_wr_en(dma_wr_en), .dma_wr_buf(dma_wr_buf), .dma_wr_off(dma_wr_off),
    .dma_wr_data(dma_wr_data), .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel),
    .host_wr_arg(host_wr_arg), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg_ready(msg_ready), .irq(irq));

  function automatic logic [31:0] rel(int idx, int words);
    return {4'h1, 8'd3, 6'(idx), 14'(words * 4 - 1)};
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic v, logic [31:0] d, logic mr, logic hen, logic [1:0] hsel, logic [1:0] harg);
    logic rdy, acc, pop, ne, sb, empty;
    int np;
    @(negedge clk);
    s_valid = v; s_data = d; msg_ready = mr;
    host_wr_en = hen; host_wr_sel = hsel; host_wr_arg = harg;
    #1;
    rdy = !m_owned[m_cur] && (q.size() <= 2);
    acc = v && rdy;
    cmp("R5 R10 s_ready", s_ready, rdy);
    cmp("R2 dma_wr_en", dma_wr_en, acc);
    if (acc) begin
      cmp("R2 R4 dma_wr_buf", dma_wr_buf, m_cur);
      cmp("R2 dma_wr_off", dma_wr_off, m_fill);
      cmp("R2 dma_wr_data", dma_wr_data, d);
    end
    cmp("R9 irq", irq, m_irq);
    cmp("R10 msg_valid", msg_valid, q.size() > 0);
    if (q.size() > 0) cmp("R3 R4 R6 R7 R8 msg_data", msg_data, q[0]);
    pop = mr && q.size() > 0;
    empty = (m_fill == 0) && (m_owned == 0);
    ne = acc && empty;
    sb = acc ? ((m_fill == 7) || m_pend) : (m_pend && m_fill > 0 && q.size() <= 2);
    np = int'(ne) + int'(sb);
    m_irq = m_armed && q.size() == 0 && np > 0;
    if (hen && hsel == 2'd2) m_armed = 1'b1;
    if (m_irq) m_armed = 1'b0;
    if (pop) void'(q.pop_front());
    if (ne) q.push_back({4'h2, 8'd3, 20'd0});
    if (sb) q.push_back(rel(m_cur, m_fill + int'(acc)));
    if (hen && hsel == 2'd0) m_owned[harg] = 1'b0;
    if (sb) begin m_owned[m_cur] = 1'b1; m_cur = (m_cur + 1) % 4; m_fill = 0; end
    else if (acc) m_fill++;
    if (hen && hsel == 2'd1) m_pend = 1'b1; else if (sb) m_pend = 1'b0;
  endtask

  task automatic idle(logic mr);
    step(1'b0, 32'h0, mr, 1'b0, 2'd3, 2'd0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    cmp("R1 s_ready", s_ready, 1); cmp("R1 msg_valid", msg_valid, 0); cmp("R1 irq", irq, 0);
    for (int i = 0; i < 8; i++) step(1'b1, 32'hA000 + i, 1'b0, 1'b0, 2'd3, 2'd0);
    idle(1'b0); cmp("R8 notice word", msg_data, 32'h2030_0000);
    idle(1'b1); idle(1'b0); cmp("R3 full release", msg_data, 32'h1030_001F);
    idle(1'b1);
    step(1'b0, 0, 1'b0, 1'b1, 2'd1, 2'd0);
    step(1'b1, 32'hB1, 1'b0, 1'b0, 2'd3, 2'd0);
    idle(1'b0); cmp("R7 flush on empty", msg_data, 32'h1030_4003);
    idle(1'b1);
    step(1'b0, 0, 1'b0, 1'b1, 2'd2, 2'd0);
    for (int i = 0; i < 3; i++) step(1'b1, 32'hC0 + i, 1'b0, 1'b0, 2'd3, 2'd0);
    step(1'b0, 0, 1'b0, 1'b1, 2'd1, 2'd0);
    idle(1'b0); idle(1'b0); cmp("R6 partial release", msg_data, 32'h1030_800B);
    idle(1'b1); idle(1'b1);
    for (int i = 0; i < 8; i++) step(1'b1, 32'hD0 + i, 1'b1, 1'b0, 2'd3, 2'd0);
    step(1'b1, 32'hEE, 1'b1, 1'b0, 2'd3, 2'd0); cmp("R5 stalled", s_ready, 0);
    step(1'b0, 0, 1'b1, 1'b1, 2'd0, 2'd0);
    idle(1'b1); cmp("R5 returned", s_ready, 1);
    for (int i = 1; i < 4; i++) step(1'b0, 0, 1'b1, 1'b1, 2'd0, 2'(i));
    idle(1'b1); idle(1'b1);
    step(1'b0, 0, 1'b0, 1'b1, 2'd1, 2'd0);
    step(1'b1, 32'hF0, 1'b0, 1'b0, 2'd3, 2'd0);
    idle(1'b0); cmp("R8 notice before release", msg_data, 32'h2030_0000);
    idle(1'b1); idle(1'b0); cmp("R7 R8 release after notice", msg_data, 32'h1030_0003);
    idle(1'b1);
    for (int i = 0; i < 3000; i++) begin
      logic hen;
      hen = ($urandom % 100) < 15;
      step(($urandom % 100) < 70, $urandom, ($urandom % 100) < 60, hen,
           2'($urandom % 3), 2'($urandom % 4));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule